// File: doc/BRIEF.md
# CPU-to-PCI Address Window Decoder

This block takes a 36-bit CPU bus address and translates it into an address on one of two PCI buses. Each bus has five programmable windows. Slot 0 of each bus maps PCI I/O space and slots 1 to 4 map PCI memory space. A window is described by a base page, a size in 64 KB pages and a 64-bit remap value that gives the start of the window on the PCI side. One shared enable word switches windows on and off. A cleared bit turns its window on. Bit 20 of the same word switches on a separate 64 KB window that points at the chip's own register space. That window moves with a programmable base page.

Software programs the windows through a simple word-addressed write port. It reads them back through a combinational read port. On every clock the block looks up the CPU address presented in the previous cycle. It registers a hit flag, the enable-bit number of the winning window, the target space, the bus number and the translated 64-bit address. A configuration flag chooses whether writing a base page also loads that window's low remap bits. This lets firmware program identity-mapped windows with one write.

Top module: `pciwin_decoder`

## Requirements
- R1: After reset the enable word reads 0x1FFFFF, the internal-register base reads 0x0F000, every other register reads 0, and no lookup hits.
- R2: Window slot s of bus b is on when bit 9+5b+s of the enable word is 0 and off when it is 1. The internal-register window is on when bit 20 is 0. Writing the enable word stores its low 21 bits.
- R3: The register word address for window w=5b+s is 4w+f. Field f is 0 for the base page, 1 for the size, 2 for remap-low and 3 for remap-high. Address 40 holds the internal-register base page, 41 the enable word and 42 the configuration word, whose bit 0 is the remap lock. A base write keeps only data bits [19:0] and a size write keeps only bits [15:0]. Reads return the stored field zero-extended, and unused addresses read 0.
- R4: An enabled window hits when base*64K <= address < base*64K + (size+1)*64K, with the address page taken from bits [35:16]. Both edges are exact.
- R5: On a window hit the translated address equals remap + address - base*64K, computed modulo 2^64.
- R6: A remap-low write loads data bits [15:0] into remap bits [31:16] and keeps bits [63:32]. A remap-high write loads all 32 data bits into remap bits [63:32]. Remap-low reads return bits [31:16] and remap-high reads return bits [63:32].
- R7: While the remap lock is 0, a base write also loads data bits [15:0] into that window's remap bits [31:16]. While the lock is 1, a base write leaves the remap unchanged.
- R8: For the I/O slot of each bus, remap-high writes are ignored. Remap-high reads return 0 and the translated address never carries upper remap bits from such a write.
- R9: A hit reports a window number equal to the window's enable-bit number. It reports space code 1 for an I/O slot, 2 for a memory slot and 3 for the internal-register window, with the bus number set to b for PCI windows and 0 for the internal-register window.
- R10: When several enabled windows hit, the one with the lowest enable-bit number wins. The internal-register window wins only when no PCI window hits.
- R11: The internal-register window covers one 64 KB page at its base page. Its translated address is the CPU address bits [15:0], zero-extended.
- R12: Lookup results appear one clock after the CPU address is sampled. On a miss the hit flag, window number, space code, bus and translated address are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register write word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 6 | Register read word address |
| cfg_rdata | output | 32 | Register read data, combinational |
| cpu_addr | input | 36 | CPU bus address to translate |
| xl_hit | output | 1 | A window matched |
| xl_win | output | 5 | Enable-bit number of the winning window |
| xl_space | output | 2 | 0 none, 1 PCI I/O, 2 PCI memory, 3 internal registers |
| xl_bus | output | 1 | PCI bus number of the hit |
| xl_addr | output | 64 | Translated address |

## Verification
Single windows are probed at the page just below the base, at the first byte, at the last byte and at the first page past the end. These probes separate off-by-one errors in the base and in the size-plus-one limit. Overlapping windows on both buses and the internal-register window are stacked on the same page and enabled in turn. This shows whether the priority order follows the enable-bit number. Base writes with the lock flag clear and then set show whether the remap copy is gated, and remap-high writes to I/O slots show whether they are dropped. A long random phase then mixes writes with addresses over a small page range. Collisions, partial overlaps and enable changes are frequent there, and every output and read value is compared against a behavioural model on each clock.

// File: rtl/pciwin_pkg.sv
package pciwin_pkg;

  typedef enum logic [1:0] {
    SPC_NONE = 2'd0,
    SPC_IO   = 2'd1,
    SPC_MEM  = 2'd2,
    SPC_REGS = 2'd3
  } spc_e;

  localparam int FLD_BASE = 0;
  localparam int FLD_SIZE = 1;
  localparam int FLD_RLO  = 2;
  localparam int FLD_RHI  = 3;

endpackage

// File: rtl/pciwin_regs.sv
module pciwin_regs
  import pciwin_pkg::*;
#(
  parameter int BUSES    = 2,
  parameter int WPB      = 5,
  parameter int PAGE_W   = 20,
  parameter int SIZE_W   = 16,
  parameter int PG_SH    = 16,
  parameter int XA_W     = 64,
  parameter int EN_W     = 21,
  parameter int WIN_BIT0 = 9,
  parameter int REG_BIT  = 20,
  parameter int RA_W     = 6,
  parameter int DW       = 32,
  parameter logic [PAGE_W-1:0] REG_BASE_RST = '0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [RA_W-1:0]                    waddr,
  input  logic [DW-1:0]                      wdata,
  input  logic [RA_W-1:0]                    raddr,
  output logic [DW-1:0]                      rdata,
  output logic [BUSES*WPB-1:0][PAGE_W-1:0]   win_base,
  output logic [BUSES*WPB-1:0][SIZE_W-1:0]   win_size,
  output logic [BUSES*WPB-1:0][XA_W-1:0]     win_remap,
  output logic [BUSES*WPB-1:0]               win_on,
  output logic [PAGE_W-1:0]                  reg_base,
  output logic                               reg_on
);

  localparam int NWIN       = BUSES * WPB;
  localparam int ADDR_IBASE = 4 * NWIN;
  localparam int ADDR_EN    = 4 * NWIN + 1;
  localparam int ADDR_CFG   = 4 * NWIN + 2;
  localparam int LO_W       = 32 - PG_SH;
  localparam int HI_W       = XA_W - 32;

  logic [NWIN-1:0][PAGE_W-1:0] base_q, base_d;
  logic [NWIN-1:0][SIZE_W-1:0] size_q, size_d;
  logic [NWIN-1:0][LO_W-1:0]   rlo_q,  rlo_d;
  logic [NWIN-1:0][HI_W-1:0]   rhi_q,  rhi_d;
  logic [PAGE_W-1:0]           ibase_q, ibase_d;
  logic [EN_W-1:0]             en_q,   en_d;
  logic                        lock_q, lock_d;

  // next-state: decode the word address into one field update
  always_comb begin
    base_d  = base_q;
    size_d  = size_q;
    rlo_d   = rlo_q;
    rhi_d   = rhi_q;
    ibase_d = ibase_q;
    en_d    = en_q;
    lock_d  = lock_q;
    for (int w = 0; w < NWIN; w++) begin
      if (waddr == RA_W'(4*w + FLD_BASE)) begin
        base_d[w] = wdata[PAGE_W-1:0];
        if (!lock_q) rlo_d[w] = wdata[LO_W-1:0];
      end
      if (waddr == RA_W'(4*w + FLD_SIZE)) size_d[w] = wdata[SIZE_W-1:0];
      if (waddr == RA_W'(4*w + FLD_RLO))  rlo_d[w]  = wdata[LO_W-1:0];
      // I/O slots carry no upper remap bits
      if (waddr == RA_W'(4*w + FLD_RHI) && (w % WPB) != 0)
        rhi_d[w] = wdata[HI_W-1:0];
    end
    if (waddr == RA_W'(ADDR_IBASE)) ibase_d = wdata[PAGE_W-1:0];
    if (waddr == RA_W'(ADDR_EN))    en_d    = wdata[EN_W-1:0];
    if (waddr == RA_W'(ADDR_CFG))   lock_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      size_q  <= '0;
      rlo_q   <= '0;
      rhi_q   <= '0;
      ibase_q <= REG_BASE_RST;
      en_q    <= '1;
      lock_q  <= 1'b0;
    end else if (we) begin
      base_q  <= base_d;
      size_q  <= size_d;
      rlo_q   <= rlo_d;
      rhi_q   <= rhi_d;
      ibase_q <= ibase_d;
      en_q    <= en_d;
      lock_q  <= lock_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (raddr == RA_W'(4*w + FLD_BASE)) rdata = DW'(base_q[w]);
      if (raddr == RA_W'(4*w + FLD_SIZE)) rdata = DW'(size_q[w]);
      if (raddr == RA_W'(4*w + FLD_RLO))  rdata = DW'(rlo_q[w]);
      if (raddr == RA_W'(4*w + FLD_RHI))  rdata = DW'(rhi_q[w]);
    end
    if (raddr == RA_W'(ADDR_IBASE)) rdata = DW'(ibase_q);
    if (raddr == RA_W'(ADDR_EN))    rdata = DW'(en_q);
    if (raddr == RA_W'(ADDR_CFG))   rdata = DW'(lock_q);
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_out
    assign win_base[w]  = base_q[w];
    assign win_size[w]  = size_q[w];
    assign win_remap[w] = {rhi_q[w], rlo_q[w], {PG_SH{1'b0}}};
    assign win_on[w]    = ~en_q[WIN_BIT0 + w];
  end

  assign reg_base = ibase_q;
  assign reg_on   = ~en_q[REG_BIT];

endmodule

// File: rtl/pciwin_match.sv
module pciwin_match #(
  parameter int NWIN   = 10,
  parameter int PAGE_W = 20,
  parameter int SIZE_W = 16
) (
  input  logic [PAGE_W-1:0]            cpu_page,
  input  logic [NWIN-1:0][PAGE_W-1:0]  win_base,
  input  logic [NWIN-1:0][SIZE_W-1:0]  win_size,
  input  logic [NWIN-1:0]              win_on,
  output logic [NWIN-1:0]              win_hit,
  output logic [NWIN-1:0][PAGE_W-1:0]  win_off
);

  // compare in 64 KB pages: page - base must not wrap and must be <= size
  for (genvar w = 0; w < NWIN; w++) begin : g_cmp
    logic [PAGE_W-1:0] diff;
    assign diff       = cpu_page - win_base[w];
    assign win_off[w] = diff;
    assign win_hit[w] = win_on[w] && (cpu_page >= win_base[w]) &&
                        (diff <= {{(PAGE_W-SIZE_W){1'b0}}, win_size[w]});
  end

endmodule

// File: rtl/pciwin_select.sv
module pciwin_select
  import pciwin_pkg::*;
#(
  parameter int NWIN     = 10,
  parameter int WPB      = 5,
  parameter int PAGE_W   = 20,
  parameter int PG_SH    = 16,
  parameter int XA_W     = 64,
  parameter int WIN_BIT0 = 9,
  parameter int REG_BIT  = 20,
  parameter int WIN_W    = 5,
  parameter int BUS_W    = 1
) (
  input  logic [NWIN-1:0]              win_hit,
  input  logic [NWIN-1:0][PAGE_W-1:0]  win_off,
  input  logic [NWIN-1:0][XA_W-1:0]    win_remap,
  input  logic                         reg_hit,
  input  logic [PG_SH-1:0]             cpu_low,
  output logic                         sel_hit,
  output logic [WIN_W-1:0]             sel_win,
  output spc_e                         sel_space,
  output logic [BUS_W-1:0]             sel_bus,
  output logic [XA_W-1:0]              sel_addr
);

  localparam int PK_W = (NWIN > 1) ? $clog2(NWIN) : 1;

  logic             found;
  logic [PK_W-1:0]  pick;
  logic             pick_io;
  logic [BUS_W-1:0] pick_bus;

  always_comb begin
    found    = 1'b0;
    pick     = '0;
    pick_io  = 1'b0;
    pick_bus = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (win_hit[w] && !found) begin
        found    = 1'b1;
        pick     = PK_W'(w);
        pick_io  = (w % WPB) == 0;
        pick_bus = BUS_W'(w / WPB);
      end
    end
  end

  always_comb begin
    sel_hit   = 1'b0;
    sel_win   = '0;
    sel_space = SPC_NONE;
    sel_bus   = '0;
    sel_addr  = '0;
    if (found) begin
      sel_hit   = 1'b1;
      sel_win   = WIN_W'(WIN_BIT0) + WIN_W'(pick);
      sel_space = pick_io ? SPC_IO : SPC_MEM;
      sel_bus   = pick_bus;
      sel_addr  = win_remap[pick] + XA_W'({win_off[pick], cpu_low});
    end else if (reg_hit) begin
      sel_hit   = 1'b1;
      sel_win   = WIN_W'(REG_BIT);
      sel_space = SPC_REGS;
      sel_addr  = XA_W'(cpu_low);
    end
  end

endmodule

// File: rtl/pciwin_decoder.sv
module pciwin_decoder
  import pciwin_pkg::*;
#(
  parameter int BUSES    = 2,
  parameter int WPB      = 5,
  parameter int CPU_AW   = 36,
  parameter int PAGE_W   = 20,
  parameter int SIZE_W   = 16,
  parameter int XA_W     = 64,
  parameter int EN_W     = 21,
  parameter int WIN_BIT0 = 9,
  parameter int REG_BIT  = 20,
  parameter int RA_W     = 6,
  parameter int DW       = 32,
  parameter int WIN_W    = 5,
  parameter int BUS_W    = 1,
  parameter logic [PAGE_W-1:0] REG_BASE_RST = 20'h0F000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RA_W-1:0]   cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic [RA_W-1:0]   cfg_raddr,
  output logic [DW-1:0]     cfg_rdata,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic              xl_hit,
  output logic [WIN_W-1:0]  xl_win,
  output logic [1:0]        xl_space,
  output logic [BUS_W-1:0]  xl_bus,
  output logic [XA_W-1:0]   xl_addr
);

  localparam int NWIN  = BUSES * WPB;
  localparam int PG_SH = CPU_AW - PAGE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NWIN-1:0][PAGE_W-1:0] win_base;
  logic [NWIN-1:0][SIZE_W-1:0] win_size;
  logic [NWIN-1:0][XA_W-1:0]   win_remap;
  logic [NWIN-1:0]             win_on;
  logic [PAGE_W-1:0]           reg_base;
  logic                        reg_on;

  pciwin_regs #(
    .BUSES(BUSES), .WPB(WPB), .PAGE_W(PAGE_W), .SIZE_W(SIZE_W),
    .PG_SH(PG_SH), .XA_W(XA_W), .EN_W(EN_W), .WIN_BIT0(WIN_BIT0),
    .REG_BIT(REG_BIT), .RA_W(RA_W), .DW(DW), .REG_BASE_RST(REG_BASE_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .we        (cfg_we),
    .waddr     (cfg_addr),
    .wdata     (cfg_wdata),
    .raddr     (cfg_raddr),
    .rdata     (cfg_rdata),
    .win_base  (win_base),
    .win_size  (win_size),
    .win_remap (win_remap),
    .win_on    (win_on),
    .reg_base  (reg_base),
    .reg_on    (reg_on)
  );

  logic [PAGE_W-1:0]           cpu_page;
  logic [NWIN-1:0]             win_hit;
  logic [NWIN-1:0][PAGE_W-1:0] win_off;
  logic                        reg_hit;

  assign cpu_page = cpu_addr[CPU_AW-1:PG_SH];
  assign reg_hit  = reg_on && (cpu_page == reg_base);

  pciwin_match #(
    .NWIN(NWIN), .PAGE_W(PAGE_W), .SIZE_W(SIZE_W)
  ) u_match (
    .cpu_page (cpu_page),
    .win_base (win_base),
    .win_size (win_size),
    .win_on   (win_on),
    .win_hit  (win_hit),
    .win_off  (win_off)
  );

  logic             sel_hit;
  logic [WIN_W-1:0] sel_win;
  spc_e             sel_space;
  logic [BUS_W-1:0] sel_bus;
  logic [XA_W-1:0]  sel_addr;

  pciwin_select #(
    .NWIN(NWIN), .WPB(WPB), .PAGE_W(PAGE_W), .PG_SH(PG_SH), .XA_W(XA_W),
    .WIN_BIT0(WIN_BIT0), .REG_BIT(REG_BIT), .WIN_W(WIN_W), .BUS_W(BUS_W)
  ) u_sel (
    .win_hit   (win_hit),
    .win_off   (win_off),
    .win_remap (win_remap),
    .reg_hit   (reg_hit),
    .cpu_low   (cpu_addr[PG_SH-1:0]),
    .sel_hit   (sel_hit),
    .sel_win   (sel_win),
    .sel_space (sel_space),
    .sel_bus   (sel_bus),
    .sel_addr  (sel_addr)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      xl_hit   <= 1'b0;
      xl_win   <= '0;
      xl_space <= 2'd0;
      xl_bus   <= '0;
      xl_addr  <= '0;
    end else begin
      xl_hit   <= sel_hit;
      xl_win   <= sel_win;
      xl_space <= sel_space;
      xl_bus   <= sel_bus;
      xl_addr  <= sel_addr;
    end
  end

endmodule

// File: rtl/pciwin_decoder_chk.sv
module pciwin_decoder_chk #(
  parameter int BUSES    = 2,
  parameter int WPB      = 5,
  parameter int PG_SH    = 16,
  parameter int XA_W     = 64,
  parameter int EN_W     = 21,
  parameter int WIN_BIT0 = 9,
  parameter int REG_BIT  = 20,
  parameter int RA_W     = 6,
  parameter int DW       = 32,
  parameter int WIN_W    = 5,
  parameter int BUS_W    = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [RA_W-1:0]  cfg_addr,
  input logic [EN_W-1:0]  en_wdata,
  input logic [RA_W-1:0]  cfg_raddr,
  input logic [DW-1:0]    cfg_rdata,
  input logic             xl_hit,
  input logic [WIN_W-1:0] xl_win,
  input logic [1:0]       xl_space,
  input logic [BUS_W-1:0] xl_bus,
  input logic [XA_W-1:0]  xl_addr
);

  localparam int NWIN    = BUSES * WPB;
  localparam int ADDR_EN = 4 * NWIN + 1;

  assert_miss_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_hit |-> (xl_space == 2'd0 && xl_win == '0 && xl_bus == '0 && xl_addr == '0));

  assert_hit_space_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xl_hit |-> xl_space != 2'd0);

  assert_win_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xl_hit |-> ((int'(xl_win) >= WIN_BIT0 && int'(xl_win) < WIN_BIT0 + NWIN) ||
                int'(xl_win) == REG_BIT));

  assert_io_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_hit && xl_space == 2'd1) |-> ((int'(xl_win) - WIN_BIT0) % WPB == 0));

  assert_bus_num_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_hit && xl_space != 2'd3) |-> (int'(xl_bus) == (int'(xl_win) - WIN_BIT0) / WPB));

  assert_regs_offset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_hit && xl_space == 2'd3) |-> (xl_addr[XA_W-1:PG_SH] == '0 && int'(xl_win) == REG_BIT));

  assert_all_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && int'(cfg_addr) == ADDR_EN && en_wdata == {EN_W{1'b1}}) |-> ##2 !xl_hit);

  assert_io_hi_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_raddr) < 4 * NWIN && cfg_raddr[1:0] == 2'd3 &&
     ((int'(cfg_raddr) / 4) % WPB) == 0) |-> cfg_rdata == '0);

endmodule

bind pciwin_decoder pciwin_decoder_chk #(
  .BUSES(BUSES), .WPB(WPB), .PG_SH(CPU_AW - PAGE_W), .XA_W(XA_W), .EN_W(EN_W),
  .WIN_BIT0(WIN_BIT0), .REG_BIT(REG_BIT), .RA_W(RA_W), .DW(DW),
  .WIN_W(WIN_W), .BUS_W(BUS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .en_wdata  (cfg_wdata[EN_W-1:0]),
  .cfg_raddr (cfg_raddr),
  .cfg_rdata (cfg_rdata),
  .xl_hit    (xl_hit),
  .xl_win    (xl_win),
  .xl_space  (xl_space),
  .xl_bus    (xl_bus),
  .xl_addr   (xl_addr)
);

// File: tb/pciwin_decoder_tb.sv
`timescale 1ns/1ps
module pciwin_decoder_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [5:0]  cfg_raddr;
  logic [31:0] cfg_rdata;
  logic [35:0] cpu_addr;
  logic        xl_hit;
  logic [4:0]  xl_win;
  logic [1:0]  xl_space;
  logic [0:0]  xl_bus;
  logic [63:0] xl_addr;

  pciwin_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .cpu_addr(cpu_addr), .xl_hit(xl_hit), .xl_win(xl_win),
    .xl_space(xl_space), .xl_bus(xl_bus), .xl_addr(xl_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  integer vectors = 0;
  integer misses  = 0;
  string  cur_req = "R1";

  // behavioural reference state
  bit [19:0] m_base  [10];
  bit [15:0] m_size  [10];
  bit [63:0] m_remap [10];
  bit [20:0] m_en;
  bit [19:0] m_ibase;
  bit        m_lock;

  bit        e_hit;
  bit [4:0]  e_win;
  bit [1:0]  e_space;
  bit        e_bus;
  bit [63:0] e_addr;

  task automatic m_reset();
    for (int i = 0; i < 10; i++) begin
      m_base[i] = 0; m_size[i] = 0; m_remap[i] = 0;
    end
    m_en = 21'h1FFFFF; m_ibase = 20'h0F000; m_lock = 0;
  endtask

  task automatic m_write(input int a, input bit [31:0] d);
    if (a < 40) begin
      int w = a / 4;
      case (a % 4)
        0: begin
          m_base[w] = d[19:0];
          if (!m_lock) m_remap[w][31:16] = d[15:0];
        end
        1: m_size[w] = d[15:0];
        2: m_remap[w][31:16] = d[15:0];
        default: if (w % 5 != 0) m_remap[w][63:32] = d;
      endcase
    end else if (a == 40) m_ibase = d[19:0];
    else if (a == 41) m_en = d[20:0];
    else if (a == 42) m_lock = d[0];
  endtask

  function automatic bit [31:0] m_read(input int a);
    if (a < 40) begin
      int w = a / 4;
      case (a % 4)
        0: return {12'h0, m_base[w]};
        1: return {16'h0, m_size[w]};
        2: return {16'h0, m_remap[w][31:16]};
        default: return m_remap[w][63:32];
      endcase
    end
    if (a == 40) return {12'h0, m_ibase};
    if (a == 41) return {11'h0, m_en};
    if (a == 42) return {31'h0, m_lock};
    return 0;
  endfunction

  task automatic m_lookup(input bit [35:0] a);
    longint unsigned pg = a[35:16];
    e_hit = 0; e_win = 0; e_space = 0; e_bus = 0; e_addr = 0;
    for (int w = 0; w < 10; w++) begin
      if (!m_en[9+w] && pg >= m_base[w] && (pg - m_base[w]) <= m_size[w]) begin
        e_hit = 1; e_win = 5'(9 + w);
        e_space = (w % 5 == 0) ? 2'd1 : 2'd2;
        e_bus = (w >= 5);
        e_addr = m_remap[w] + 64'(a) - (64'(m_base[w]) << 16);
        return;
      end
    end
    if (!m_en[20] && pg == m_ibase) begin
      e_hit = 1; e_win = 5'd20; e_space = 2'd3; e_addr = {48'h0, a[15:0]};
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset();
      e_hit = 0; e_win = 0; e_space = 0; e_bus = 0; e_addr = 0;
    end else begin
      m_lookup(cpu_addr);
      if (cfg_we) m_write(int'(cfg_addr), cfg_wdata);
    end
  end

  always @(negedge clk) begin
    bit [31:0] er;
    er = m_read(int'(cfg_raddr));
    vectors++;
    if (xl_hit !== e_hit || xl_win !== e_win || xl_space !== e_space ||
        xl_bus !== e_bus || xl_addr !== e_addr) begin
      misses++;
      $display("FAIL %s lookup cpu=%h: got hit=%0d win=%0d spc=%0d bus=%0d addr=%h, expected hit=%0d win=%0d spc=%0d bus=%0d addr=%h",
               cur_req, cpu_addr, xl_hit, xl_win, xl_space, xl_bus, xl_addr,
               e_hit, e_win, e_space, e_bus, e_addr);
    end
    if (cfg_rdata !== er) begin
      misses++;
      $display("FAIL %s read addr=%0d: got %h expected %h", cur_req, cfg_raddr, cfg_rdata, er);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic wr(input int a, input bit [31:0] d);
    cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic probe(input bit [35:0] a);
    cpu_addr = a;
    tick(2);
  endtask

  task automatic rd(input int a);
    cfg_raddr = 6'(a);
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got no completion, expected end of stimulus");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; cfg_raddr = 0; cpu_addr = 0;
    tick(3);
    rst_n = 1;
    tick(4);

    // R1: reset values of every register, no hit anywhere
    cur_req = "R1";
    for (int a = 0; a < 48; a++) rd(a);
    probe(36'h0_0F00_0000);
    probe(36'h0_0000_0000);

    // R3: field masking and read-back
    cur_req = "R3";
    wr(4, 32'hFFFA_B123); rd(4); rd(6);
    wr(5, 32'hDEAD_BEEF); rd(5);
    wr(63, 32'h1234_5678); rd(63);

    // R4 / R2: window edges on bus 0 memory slot 1 (enable bit 10)
    cur_req = "R4";
    wr(4, 32'h0000_0100); wr(5, 2); wr(6, 0);
    wr(41, 32'h001F_FBFF); rd(41);
    probe(36'h0_00FF_FFFF);
    probe(36'h0_0100_0000);
    probe(36'h0_0102_FFFF);
    probe(36'h0_0103_0000);
    probe(36'hF_0100_0000);
    cur_req = "R2";
    wr(41, 32'hFFFF_FFFF); rd(41);
    probe(36'h0_0100_0000);
    wr(41, 32'h001F_FBFF);

    // R6 / R5: remap halves and translation
    cur_req = "R6";
    wr(6, 32'hAAAA_8000); wr(7, 32'h0000_0001); rd(6); rd(7);
    cur_req = "R5";
    probe(36'h0_0101_2345);
    probe(36'h0_0102_FFFF);

    // R7: base write copies into remap-low only while unlocked
    cur_req = "R7";
    wr(4, 32'h0000_0120); rd(6); rd(7);
    wr(42, 1); rd(42);
    wr(4, 32'h0000_0100); rd(6);
    probe(36'h0_0100_0004);
    wr(42, 0);

    // R8: I/O slot ignores upper remap
    cur_req = "R8";
    wr(3, 32'hFFFF_FFFF); rd(3);
    wr(0, 32'h0000_0200); wr(1, 0); wr(2, 32'h0000_4000);
    wr(23, 32'hCAFE_F00D); rd(23);
    wr(41, 32'h001F_F9FF);
    probe(36'h0_0200_1234);

    // R9: bus 1 memory slot (enable bit 16) and bus 1 I/O slot (bit 14)
    cur_req = "R9";
    wr(28, 32'h0000_0300); wr(29, 1); wr(30, 32'h0000_0010);
    wr(20, 32'h0000_0400); wr(21, 0);
    wr(41, 32'h001E_B9FF);
    probe(36'h0_0301_0000);
    probe(36'h0_0400_FFFF);

    // R10: overlap priority
    cur_req = "R10";
    wr(24, 32'h0000_0300); wr(25, 0);
    wr(41, 32'h001E_39FF);
    probe(36'h0_0300_0010);
    wr(4, 32'h0000_0300);
    probe(36'h0_0300_0010);
    probe(36'h0_0301_0010);

    // R11: internal-register window and its priority
    cur_req = "R11";
    wr(40, 32'hFFF0_0500); rd(40);
    wr(41, 32'h000E_39FF);
    probe(36'h0_0500_ABCD);
    wr(4, 32'h0000_0500);
    probe(36'h0_0500_ABCD);
    wr(41, 32'h001E_39FF);
    probe(36'h0_0500_ABCD);

    // R12: lookups change every cycle, result one clock later
    cur_req = "R12";
    for (int i = 0; i < 16; i++) begin
      cpu_addr = {16'h0, 4'(i), 16'(i * 4099)};
      tick();
    end

    // mixed random phase
    cur_req = "R4 R5 R10 R7";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 2) == 0) begin
        int a = $urandom_range(0, 42);
        bit [31:0] d = $urandom;
        if (a < 40 && a % 4 == 0) d = d & 32'hFFF0_000F;
        if (a < 40 && a % 4 == 1) d = d & 32'hFFFF_0003;
        if (a == 40) d = d & 32'hFFF0_001F;
        cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = d;
      end else begin
        cfg_we = 0;
      end
      cfg_raddr = 6'($urandom_range(0, 45));
      cpu_addr  = {16'h0, 4'($urandom_range(0, 15)), 16'($urandom)};
      if ($urandom_range(0, 15) == 0) cpu_addr[35:20] = 16'($urandom_range(0, 1));
      tick();
    end
    cfg_we = 0;
    tick(3);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule